// File: doc/BRIEF.md
# Packet Error Rate Meter

This block measures the packet error rate seen on a link. Software writes a packet-budget multiplier to a control register. The block then counts the packets that arrive on a per-packet strobe and, separately, the packets whose error flag is set. It stops when the budget is used up. Completion is shown in a status register, and the error tally is read back one byte at a time.

The budget is programmed in coarse units of 2^UNIT_LOG2 packets, which is 65536 packets by default. A written value N therefore asks for N × 2^UNIT_LOG2 packets. Writing zero abandons the measurement and clears it. Writing a nonzero value at any time starts a fresh measurement from zero. Packets are only counted while the link-up input is high, because results taken without a live link are meaningless.

Top module: `per_meter`

## Requirements
- R1: After reset, the three result bytes and the status done bit all read 0.
- R2: Writing 0x00 to the control register (address 0x10) returns the block to idle, with the error tally at 0 and done at 0. Strobes that follow are not counted.
- R3: Writing a nonzero N to address 0x10 starts a measurement of exactly N × 2^UNIT_LOG2 counted packets. Done is still 0 after one packet fewer than that, and becomes 1 in the cycle after the final packet is counted.
- R4: The status register (address 0x14) reads done in bit 0 and the current link-up input level in bit 1. All its other bits read 0.
- R5: A packet strobe that arrives while link-up is low is not counted, either as a packet or as an error.
- R6: A counted strobe with the error flag high adds exactly one to the error tally. A counted strobe with the error flag low leaves the tally unchanged.
- R7: The error tally saturates at its all-ones value (2^ERR_W − 1) and never wraps.
- R8: A nonzero write made while a measurement is running restarts it: the tally and the packet count go back to zero and the new budget applies.
- R9: Once done is set, further strobes change neither the tally nor done until the next write to address 0x10.
- R10: The error tally reads back zero-extended to 24 bits. Bits [7:0] are at address 0x11, bits [15:8] at 0x12 and bits [23:16] at 0x13.
- R11: Strobes that arrive in idle, before any measurement has been started, are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pktStrobe | input | 1 | One-cycle pulse for each received packet |
| pktErr | input | 1 | Marks the packet on the strobe as errored |
| linkUp | input | 1 | Link is established |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |

## Verification
The assertions check every cycle that the error tally never steps by more than one and never leaves its saturated value. They also check that the tally and packet count hold still while the link is down and after completion, and that a zero write leaves everything cleared. Only the bench scenarios can show that done rises on exactly the budgeted packet, and that errors are tallied for the right packets. The same holds for a restart discarding earlier counts and for the byte placement of the tally. To keep run time short, the bench uses a small budget unit and a narrow error counter.

// File: rtl/per_pkg.sv
package per_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h10;
  localparam logic [7:0] ADDR_RES0   = 8'h11;
  localparam logic [7:0] ADDR_RES1   = 8'h12;
  localparam logic [7:0] ADDR_RES2   = 8'h13;
  localparam logic [7:0] ADDR_STATUS = 8'h14;
  localparam int         RES_W       = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } perState_e;

  typedef struct packed {
    logic clear;   // zero both counters
    logic load;    // capture a new budget
    logic count;   // a packet is accepted this cycle
  } perStrobes_t;
endpackage

// File: rtl/per_ctrl.sv
module per_ctrl
  import per_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktStrobe,
  input  logic        linkUp,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  logic        lastPkt,
  output perStrobes_t strb,
  output logic        done
);
  perState_e state, stateNext;
  logic      ctrlWr;
  logic      startReq;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_CTRL);
  assign startReq = ctrlWr && (regWrData != 8'h00);

  always_comb begin
    strb.clear = ctrlWr;
    strb.load  = startReq;
    strb.count = (state == ST_RUN) && pktStrobe && linkUp && !ctrlWr;
  end

  always_comb begin
    stateNext = state;
    if (ctrlWr) begin
      stateNext = startReq ? ST_RUN : ST_IDLE;
    end else if (strb.count && lastPkt) begin
      stateNext = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/per_datapath.sv
module per_datapath
  import per_pkg::*;
#(
  parameter int UNIT_LOG2 = 16,
  parameter int ERR_W     = 24,
  localparam int CNT_W    = 8 + UNIT_LOG2
)(
  input  logic             clk,
  input  logic             rstN,
  input  perStrobes_t      strb,
  input  logic             pktErr,
  input  logic [7:0]       regWrData,
  input  logic [7:0]       regAddr,
  input  logic             done,
  input  logic             linkUp,
  output logic             lastPkt,
  output logic [CNT_W-1:0] pktCnt,
  output logic [ERR_W-1:0] errCnt,
  output logic [7:0]       regRdData
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] pktNext;
  logic [RES_W-1:0] errWide;

  assign pktNext = pktCnt + 1'b1;
  assign lastPkt = (pktNext == target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktCnt <= '0;
      errCnt <= '0;
      target <= '0;
    end else if (strb.clear) begin
      pktCnt <= '0;
      errCnt <= '0;
      if (strb.load) target <= {regWrData, {UNIT_LOG2{1'b0}}};
    end else if (strb.count) begin
      pktCnt <= pktNext;
      if (pktErr && (errCnt != ERR_MAX)) errCnt <= errCnt + 1'b1;
    end
  end

  assign errWide = RES_W'(errCnt);

  always_comb begin
    case (regAddr)
      ADDR_RES0:   regRdData = errWide[7:0];
      ADDR_RES1:   regRdData = errWide[15:8];
      ADDR_RES2:   regRdData = errWide[23:16];
      ADDR_STATUS: regRdData = {6'b0, linkUp, done};
      default:     regRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/per_meter.sv
module per_meter
  import per_pkg::*;
#(
  parameter int UNIT_LOG2 = 16,
  parameter int ERR_W     = 24,
  localparam int CNT_W    = 8 + UNIT_LOG2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktStrobe,
  input  logic       pktErr,
  input  logic       linkUp,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData
);
  perStrobes_t      strb;
  logic             done;
  logic             lastPkt;
  logic [CNT_W-1:0] pktCnt;
  logic [ERR_W-1:0] errCnt;

  per_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pktStrobe(pktStrobe), .linkUp(linkUp),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .lastPkt(lastPkt), .strb(strb), .done(done)
  );

  per_datapath #(.UNIT_LOG2(UNIT_LOG2), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pktErr(pktErr),
    .regWrData(regWrData), .regAddr(regAddr), .done(done), .linkUp(linkUp),
    .lastPkt(lastPkt), .pktCnt(pktCnt), .errCnt(errCnt), .regRdData(regRdData)
  );
endmodule

// File: rtl/per_meter_chk.sv
module per_meter_chk
  import per_pkg::*;
#(
  parameter int UNIT_LOG2 = 16,
  parameter int ERR_W     = 24,
  localparam int CNT_W    = 8 + UNIT_LOG2
)(
  input logic             clk,
  input logic             rstN,
  input logic             linkUp,
  input logic             regWrEn,
  input logic [7:0]       regAddr,
  input logic [7:0]       regWrData,
  input logic             done,
  input logic [CNT_W-1:0] pktCnt,
  input logic [ERR_W-1:0] errCnt
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);

  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> (errCnt == $past(errCnt)) || (errCnt == $past(errCnt) + 1'b1));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWr && errCnt == ERR_MAX) |=> errCnt == ERR_MAX);

  // R5
  link_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWr && !linkUp) |=> $stable(pktCnt) && $stable(errCnt));

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWr && done) |=> done && $stable(pktCnt) && $stable(errCnt));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData == 8'h00) |=> !done && errCnt == '0 && pktCnt == '0);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData != 8'h00) |=> !done && errCnt == '0 && pktCnt == '0);
endmodule

bind per_meter per_meter_chk #(.UNIT_LOG2(UNIT_LOG2), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .linkUp(linkUp), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .done(done),
  .pktCnt(pktCnt), .errCnt(errCnt)
);

// File: tb/per_meter_test.sv
`timescale 1ns/1ps
module per_meter_test;
  localparam int UNIT_LOG2 = 4;
  localparam int ERR_W     = 10;
  localparam int ERR_MAX   = (1 << ERR_W) - 1;

  logic       clk = 0;
  logic       rstN = 0;
  logic       pktStrobe = 0, pktErr = 0, linkUp = 0;
  logic       regWrEn = 0;
  logic [7:0] regAddr = 0, regWrData = 0;
  logic [7:0] regRdData;

  int errors = 0, checks = 0, cycles = 0;
  // reference model state
  int  expPkt = 0, expErr = 0, expTarget = 0;
  bit  expRun = 0, expDone = 0;

  per_meter #(.UNIT_LOG2(UNIT_LOG2), .ERR_W(ERR_W)) uut (
    .clk(clk), .rstN(rstN), .pktStrobe(pktStrobe), .pktErr(pktErr),
    .linkUp(linkUp), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic writeCtrl(input logic [7:0] n);
    @(negedge clk);
    regWrEn = 1; regAddr = 8'h10; regWrData = n;
    @(negedge clk);
    regWrEn = 0;
    expPkt = 0; expErr = 0; expDone = 0;
    expRun = (n != 0);
    expTarget = int'(n) << UNIT_LOG2;
  endtask

  // send n back-to-back packets; every errEvery-th one (starting at the first) is errored
  task automatic sendPkts(input int n, input int errEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pktStrobe = 1;
      pktErr = (errEvery != 0) && (i % errEvery == 0);
      if (expRun && linkUp) begin
        expPkt++;
        if (pktErr && expErr < ERR_MAX) expErr++;
        if (expPkt == expTarget) begin expRun = 0; expDone = 1; end
      end
    end
    @(negedge clk);
    pktStrobe = 0; pktErr = 0;
  endtask

  task automatic checkResult(input string req);
    logic [7:0] b0, b1, b2, st;
    readReg(8'h11, b0);
    readReg(8'h12, b1);
    readReg(8'h13, b2);
    readReg(8'h14, st);
    check(req, "error tally", int'({b2, b1, b0}), expErr);
    check(req, "status", int'(st), (int'(linkUp) << 1) | int'(expDone));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    readReg(8'h11, d); check("R1", "byte0", d, 0);
    readReg(8'h12, d); check("R1", "byte1", d, 0);
    readReg(8'h13, d); check("R1", "byte2", d, 0);
    readReg(8'h14, d); check("R4", "status at reset", d, 0);
  endtask

  task automatic t_idle();
    linkUp = 1;
    sendPkts(5, 1);
    checkResult("R11");
  endtask

  task automatic t_basic();
    writeCtrl(8'd2);               // 32 packets
    sendPkts(31, 4);               // 8 errored
    checkResult("R3");
    check("R6", "errors before end", expErr, 8);
    sendPkts(1, 1);                // final, errored
    checkResult("R3");
    check("R3", "done model", int'(expDone), 1);
  endtask

  task automatic t_bytes();
    logic [7:0] d;
    readReg(8'h11, d); check("R10", "low byte", d, 9);
    readReg(8'h12, d); check("R10", "mid byte", d, 0);
  endtask

  task automatic t_frozen();
    sendPkts(10, 1);
    checkResult("R9");
  endtask

  task automatic t_link();
    writeCtrl(8'd1);
    linkUp = 0;
    sendPkts(20, 1);
    checkResult("R5");
    linkUp = 1;
    sendPkts(16, 1);
    checkResult("R5");
    check("R6", "all errored", expErr, 16);
  endtask

  task automatic t_restart();
    writeCtrl(8'd3);
    sendPkts(10, 1);
    checkResult("R8");
    writeCtrl(8'd1);
    checkResult("R8");
    sendPkts(15, 5);               // 3 errored
    checkResult("R8");
    sendPkts(1, 0);
    checkResult("R8");
    check("R8", "done after new budget", int'(expDone), 1);
  endtask

  task automatic t_clear();
    writeCtrl(8'd0);
    checkResult("R2");
    sendPkts(8, 1);
    checkResult("R2");
  endtask

  task automatic t_sat();
    logic [7:0] d;
    writeCtrl(8'd80);              // 1280 packets
    sendPkts(1100, 1);
    checkResult("R7");
    readReg(8'h11, d); check("R7", "sat low byte", d, 8'hFF);
    readReg(8'h12, d); check("R10", "sat mid byte", d, 8'h03);
    sendPkts(180, 1);
    checkResult("R7");
    check("R7", "done at end", int'(expDone), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_idle();
    t_basic();
    t_bytes();
    t_frozen();
    t_link();
    t_restart();
    t_clear();
    t_sat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule